// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

This peripheral lets two processors signal each other through interrupts. Each processor owns a 4-bit doorbell status word. A write-one-to-set register ORs bits into a word, and a write-one-to-clear register removes them. While a processor's word is nonzero, its level interrupt output stays high. A sender rings a doorbell by setting a bit in the receiver's word. The receiver handles the event and then clears that bit.

The unit occupies a 4 KB window on a 32-bit APB-style register bus with zero wait states. The top of the window holds a read-only identification block of twelve words. An illegal access completes with a slave-error response and also raises a one-cycle error pulse. Illegal accesses are wrong-direction accesses, unmapped or misaligned offsets, and partial byte strobes.

The bus interface is a small state machine with three states. `ST_IDLE` moves to `ST_SETUP` when `psel` rises without `penable`. `ST_SETUP` moves to `ST_ACCESS` when `penable` follows; that move is the transfer. `ST_SETUP` returns to `ST_IDLE` if `psel` drops. `ST_ACCESS` moves to `ST_SETUP` when a new setup phase starts back to back, and otherwise returns to `ST_IDLE`.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset both status words are zero, both interrupt outputs are low and the error pulse is low.
- R2: The CPU0 status, set and clear registers sit at offsets 0x000, 0x004 and 0x008. The CPU1 registers sit at 0x010, 0x014 and 0x018. A status read returns the word in bits [3:0] and zeros in bits [31:4].
- R3: A legal write to a set register ORs write data bits [3:0] into that CPU's status word. Data bits [31:4] are ignored, and the other CPU's word is left unchanged.
- R4: A legal write to a clear register zeroes every status bit whose position is 1 in write data bits [3:0]. Data bits [31:4] are ignored.
- R5: Each interrupt output is high exactly when its CPU's status word is nonzero. The output is registered, so it changes on the clock edge after the edge that commits the write.
- R6: Reads at 0xFD0, 0xFD4 and so on up to 0xFFC return, in bits [7:0], the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order. Bits [31:8] read as zero.
- R7: A read of any set or clear register returns zero and is flagged as an error.
- R8: A write to a status register or an identification register changes no state and is flagged as an error.
- R9: A read of an unmapped or non-word-aligned offset returns zero and is flagged as an error. A write to such an offset is discarded and is flagged as an error.
- R10: An access whose byte strobes `pstrb` are not 4'b1111 is illegal. It changes no state, reads zero and is flagged as an error.
- R11: For an error, `pslverr` is high in the access phase of the transfer. `err_pulse` is then high for exactly the following cycle. A legal transfer raises neither signal.
- R12: A transfer takes effect only in an access phase (`psel` and `penable` high) that directly follows a setup phase. `pready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; all four must be set |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, always high |
| pslverr | output | 1 | Error response in the access phase |
| irq | output | 2 | Level interrupt per CPU, bit i for CPU i |
| err_pulse | output | 1 | One-cycle pulse after an illegal access |

## Verification
A reference model of both status words follows every bus write, and status reads and interrupt levels are compared against it. Set and clear are applied in turn to the same bit to separate OR/AND-NOT behaviour from plain overwrite. Data with bits [31:4] set checks that the 4-bit valid mask is applied on both the set and the clear paths. Writes to one CPU are checked against the other CPU's word to show the two words are independent. The illegal cases (wrong direction, unmapped, misaligned, partial strobe) each check the zero read data, the error response and the one-cycle pulse. Each of them also checks that no state changed. The interrupt is sampled both one cycle after the write and in the cycle after that, to pin down the registered delay.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_STAT = 3'd1,
        RG_SET  = 3'd2,
        RG_CLR  = 3'd3,
        RG_ID   = 3'd4
    } reg_kind_e;

    // identification byte for word index idx of the ID block
    function automatic logic [7:0] id_byte(input int unsigned idx);
        logic [7:0] b;
        case (idx)
            0:       b = 8'h04;
            4:       b = 8'h56;
            5:       b = 8'hB8;
            6:       b = 8'h0B;
            8:       b = 8'h0D;
            9:       b = 8'hF0;
            10:      b = 8'h05;
            11:      b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dbell_bus_fsm.sv
module dbell_bus_fsm
    import ipc_doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic bad_access,
    output logic xfer,
    output logic pready,
    output logic pslverr,
    output logic err_pulse
);

    bus_state_e state_q, state_d;
    logic       err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (!psel)              state_d = ST_IDLE;
                else if (penable)       state_d = ST_ACCESS;
                else                    state_d = ST_SETUP;
            end
            ST_ACCESS: begin
                if (psel && !penable)   state_d = ST_SETUP;
                else                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        xfer    = (state_q == ST_SETUP) && psel && penable;
        pready  = 1'b1;
        pslverr = xfer && bad_access;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= xfer && bad_access;
        end
    end

    assign err_pulse = err_q;

endmodule

// File: rtl/dbell_decode.sv
module dbell_decode
    import ipc_doorbell_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              NUM_CPU   = 2,
    parameter int              ID_WORDS  = 12,
    parameter logic [ADDR_W-1:0] ID_BASE = 12'hFD0,
    localparam int             CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int             ID_IDX_W  = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
    input  logic [ADDR_W-1:0]    paddr,
    input  logic                 pwrite,
    input  logic [3:0]           pstrb,
    output reg_kind_e            kind,
    output logic [CPU_IDX_W-1:0] cpu,
    output logic [ID_IDX_W-1:0]  id_idx,
    output logic                 bad_access
);

    localparam int unsigned ID_LO = 32'(ID_BASE);
    localparam int unsigned ID_HI = ID_LO + 4 * ID_WORDS;

    logic [31:0] addr32;
    logic [31:0] cpu_field;

    assign addr32    = 32'(paddr);
    assign cpu_field = 32'(paddr[ADDR_W-1:4]);

    always_comb begin
        kind   = RG_NONE;
        cpu    = '0;
        id_idx = '0;
        if (paddr[1:0] == 2'b00) begin
            if (addr32 >= ID_LO && addr32 < ID_HI) begin
                kind   = RG_ID;
                id_idx = ID_IDX_W'((addr32 - ID_LO) >> 2);
            end else if (cpu_field < 32'(NUM_CPU)) begin
                cpu = CPU_IDX_W'(cpu_field);
                case (paddr[3:2])
                    2'd0:    kind = RG_STAT;
                    2'd1:    kind = RG_SET;
                    2'd2:    kind = RG_CLR;
                    default: kind = RG_NONE;
                endcase
            end
        end
    end

    always_comb begin
        bad_access = 1'b0;
        if (pstrb != 4'hF)                                    bad_access = 1'b1;
        if (kind == RG_NONE)                                  bad_access = 1'b1;
        if (pwrite && (kind == RG_STAT || kind == RG_ID))     bad_access = 1'b1;
        if (!pwrite && (kind == RG_SET || kind == RG_CLR))    bad_access = 1'b1;
    end

endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
    parameter int VALID_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [VALID_W-1:0] wmask,
    output logic [VALID_W-1:0] stat,
    output logic               irq
);

    logic [VALID_W-1:0] stat_q;
    logic               irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (set_we) begin
            stat_q <= stat_q | wmask;
        end else if (clr_we) begin
            stat_q <= stat_q & ~wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |stat_q;
        end
    end

    assign stat = stat_q;
    assign irq  = irq_q;

endmodule

// File: rtl/dbell_id_rom.sv
module dbell_id_rom
    import ipc_doorbell_pkg::*;
#(
    parameter int  DATA_W   = 32,
    parameter int  ID_WORDS = 12,
    localparam int ID_IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
    input  logic [ID_IDX_W-1:0] id_idx,
    output logic [DATA_W-1:0]   id_word
);

    always_comb begin
        id_word = DATA_W'(id_byte(32'(id_idx)));
    end

endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
    import ipc_doorbell_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter int                NUM_CPU  = 2,
    parameter int                VALID_W  = 4,
    parameter int                ID_WORDS = 12,
    parameter logic [ADDR_W-1:0] ID_BASE  = 12'hFD0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    input  logic [3:0]         pstrb,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    output logic [NUM_CPU-1:0] irq,
    output logic               err_pulse
);

    localparam int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int ID_IDX_W  = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;

    reg_kind_e                        kind;
    logic [CPU_IDX_W-1:0]             cpu;
    logic [ID_IDX_W-1:0]              id_idx;
    logic                             bad_access;
    logic                             xfer;
    logic                             wr_ok;
    logic [DATA_W-1:0]                id_word;
    logic [NUM_CPU-1:0][VALID_W-1:0]  stat;
    logic                             unused_wdata_hi;

    assign unused_wdata_hi = ^pwdata[DATA_W-1:VALID_W];

    dbell_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CPU  (NUM_CPU),
        .ID_WORDS (ID_WORDS),
        .ID_BASE  (ID_BASE)
    ) u_decode (
        .paddr      (paddr),
        .pwrite     (pwrite),
        .pstrb      (pstrb),
        .kind       (kind),
        .cpu        (cpu),
        .id_idx     (id_idx),
        .bad_access (bad_access)
    );

    dbell_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .bad_access (bad_access),
        .xfer       (xfer),
        .pready     (pready),
        .pslverr    (pslverr),
        .err_pulse  (err_pulse)
    );

    dbell_id_rom #(
        .DATA_W   (DATA_W),
        .ID_WORDS (ID_WORDS)
    ) u_id (
        .id_idx  (id_idx),
        .id_word (id_word)
    );

    assign wr_ok = xfer && pwrite && !bad_access;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic sel;
        assign sel = (32'(cpu) == i);
        dbell_status #(
            .VALID_W (VALID_W)
        ) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wr_ok && sel && (kind == RG_SET)),
            .clr_we (wr_ok && sel && (kind == RG_CLR)),
            .wmask  (pwdata[VALID_W-1:0]),
            .stat   (stat[i]),
            .irq    (irq[i])
        );
    end

    always_comb begin
        prdata = '0;
        if (xfer && !pwrite && !bad_access) begin
            if (kind == RG_STAT)    prdata = DATA_W'(stat[cpu]);
            else if (kind == RG_ID) prdata = id_word;
        end
    end

endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_CPU = 2,
    parameter int VALID_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [VALID_W-1:0] wdata_lo,
    input logic [3:0]         pstrb,
    input logic [DATA_W-1:0]  prdata,
    input logic               pslverr,
    input logic [NUM_CPU-1:0] irq,
    input logic               err_pulse
);

    logic was_setup;
    logic acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) was_setup <= 1'b0;
        else        was_setup <= psel && !penable;
    end

    assign acc = was_setup && psel && penable;

    AST_SET0_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && paddr == ADDR_W'(4) && pstrb == 4'hF && |wdata_lo) |-> ##2 irq[0]); // R5

    AST_SET1_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && paddr == ADDR_W'(20) && pstrb == 4'hF && |wdata_lo) |-> ##2 irq[1]); // R3

    AST_CLR0_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pwrite && paddr == ADDR_W'(8) && pstrb == 4'hF && &wdata_lo) |-> ##2 !irq[0]); // R4

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pslverr) |-> (prdata == '0)); // R9

    AST_SETREG_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pwrite && (paddr == ADDR_W'(4) || paddr == ADDR_W'(24))) |-> (pslverr && prdata == '0)); // R7

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pwrite && paddr == ADDR_W'(0)) |-> (prdata[DATA_W-1:VALID_W] == '0)); // R2

    AST_PARTIAL_STRB_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pstrb != 4'hF) |-> pslverr); // R10

    AST_ERR_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pslverr) |=> err_pulse); // R11

    AST_ERR_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse); // R11

    AST_NO_ERR_OUTSIDE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> !pslverr); // R12

endmodule

bind ipc_doorbell ipc_doorbell_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_CPU (NUM_CPU),
    .VALID_W (VALID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .wdata_lo  (pwdata[VALID_W-1:0]),
    .pstrb     (pstrb),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .irq       (irq),
    .err_pulse (err_pulse)
);

// File: tb/ipc_doorbell_tb.sv
`timescale 1ns/1ps
module ipc_doorbell_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [1:0]  irq;
    logic        err_pulse;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m0 = '0;
    logic [3:0] m1 = '0;

    always #5 clk = ~clk;

    ipc_doorbell u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .irq(irq), .err_pulse(err_pulse)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // reference model: apply a legal write
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h004: m0 = m0 | d[3:0];
            12'h008: m0 = m0 & ~d[3:0];
            12'h014: m1 = m1 | d[3:0];
            12'h018: m1 = m1 & ~d[3:0];
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [3:0] s, input logic exp_err, input string req);
        logic [1:0] old_irq;
        old_irq = {|m1, |m0};
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk(pready === 1'b1, "R12", "pready in write access", 32'(pready), 32'd1);
        chk(pslverr === exp_err, req, "pslverr on write", 32'(pslverr), 32'(exp_err));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk(err_pulse === exp_err, "R11", "err_pulse after write", 32'(err_pulse), 32'(exp_err));
        chk(irq === old_irq, "R5", "irq one cycle after write (old level)", 32'(irq), 32'(old_irq));
        if (!exp_err) model_write(a, d);
        @(negedge clk);
        #1;
        chk(err_pulse === 1'b0, "R11", "err_pulse width", 32'(err_pulse), 32'd0);
        chk(irq === {|m1, |m0}, req, "irq two cycles after write", 32'(irq), 32'({|m1, |m0}));
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [3:0] s,
                            input logic [31:0] exp_d, input logic exp_err, input string req);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk(prdata === exp_d, req, "prdata", prdata, exp_d);
        chk(pslverr === exp_err, req, "pslverr on read", 32'(pslverr), 32'(exp_err));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        chk(err_pulse === exp_err, "R11", "err_pulse after read", 32'(err_pulse), 32'(exp_err));
    endtask

    task automatic check_state(input string req);
        bus_read(12'h000, 4'hF, 32'(m0), 1'b0, req);
        bus_read(12'h010, 4'hF, 32'(m1), 1'b0, req);
    endtask

    task automatic t_reset;
        #1;
        chk(irq === 2'b00, "R1", "irq in reset", 32'(irq), 32'd0);
        chk(err_pulse === 1'b0, "R1", "err_pulse in reset", 32'(err_pulse), 32'd0);
        check_state("R1");
    endtask

    task automatic t_set_clear;
        bus_write(12'h004, 32'h0000_0005, 4'hF, 1'b0, "R3");
        check_state("R3");
        bus_write(12'h014, 32'h0000_0002, 4'hF, 1'b0, "R3");
        check_state("R2");
        bus_write(12'h008, 32'h0000_0001, 4'hF, 1'b0, "R4");
        check_state("R4");
        bus_write(12'h008, 32'h0000_0004, 4'hF, 1'b0, "R5");
        check_state("R5");
        bus_write(12'h018, 32'h0000_000F, 4'hF, 1'b0, "R4");
        check_state("R4");
    endtask

    task automatic t_same_bit;
        bus_write(12'h014, 32'h0000_0008, 4'hF, 1'b0, "R3");
        bus_write(12'h018, 32'h0000_0008, 4'hF, 1'b0, "R4");
        bus_write(12'h014, 32'h0000_0008, 4'hF, 1'b0, "R3");
        bus_write(12'h014, 32'h0000_0008, 4'hF, 1'b0, "R3");
        check_state("R3");
        bus_write(12'h018, 32'h0000_0000, 4'hF, 1'b0, "R4");
        check_state("R4");
    endtask

    task automatic t_upper_bits;
        bus_write(12'h004, 32'hFFFF_FFF0, 4'hF, 1'b0, "R3");
        check_state("R3");
        bus_write(12'h004, 32'hABCD_0123, 4'hF, 1'b0, "R3");
        check_state("R2");
        bus_write(12'h008, 32'h1234_5670, 4'hF, 1'b0, "R4");
        check_state("R4");
        bus_write(12'h008, 32'hFFFF_FFFF, 4'hF, 1'b0, "R4");
        check_state("R4");
    endtask

    task automatic t_id;
        for (int k = 0; k < 12; k++) begin
            logic [7:0] b;
            case (k)
                0: b = 8'h04; 4: b = 8'h56; 5: b = 8'hB8; 6: b = 8'h0B;
                8: b = 8'h0D; 9: b = 8'hF0; 10: b = 8'h05; 11: b = 8'hB1;
                default: b = 8'h00;
            endcase
            bus_read(12'hFD0 + 12'(4 * k), 4'hF, 32'(b), 1'b0, "R6");
        end
    endtask

    task automatic t_illegal;
        bus_write(12'h004, 32'h3, 4'hF, 1'b0, "R3");
        bus_read(12'h004, 4'hF, 32'd0, 1'b1, "R7");
        bus_read(12'h008, 4'hF, 32'd0, 1'b1, "R7");
        bus_read(12'h014, 4'hF, 32'd0, 1'b1, "R7");
        bus_read(12'h018, 4'hF, 32'd0, 1'b1, "R7");
        bus_write(12'h000, 32'hF, 4'hF, 1'b1, "R8");
        bus_write(12'h010, 32'hF, 4'hF, 1'b1, "R8");
        bus_write(12'hFE0, 32'hF, 4'hF, 1'b1, "R8");
        bus_read(12'hFE0, 4'hF, 32'h56, 1'b0, "R8");
        check_state("R8");
        bus_read(12'h00C, 4'hF, 32'd0, 1'b1, "R9");
        bus_read(12'h020, 4'hF, 32'd0, 1'b1, "R9");
        bus_read(12'h800, 4'hF, 32'd0, 1'b1, "R9");
        bus_read(12'h002, 4'hF, 32'd0, 1'b1, "R9");
        bus_write(12'h024, 32'hF, 4'hF, 1'b1, "R9");
        bus_write(12'h005, 32'hF, 4'hF, 1'b1, "R9");
        bus_write(12'h015, 32'hF, 4'hF, 1'b1, "R9");
        check_state("R9");
        bus_write(12'h014, 32'hF, 4'h7, 1'b1, "R10");
        bus_write(12'h008, 32'hF, 4'h1, 1'b1, "R10");
        bus_read(12'h000, 4'h0, 32'd0, 1'b1, "R10");
        check_state("R10");
    endtask

    task automatic t_protocol;
        // penable without a preceding setup phase: no transfer
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h014; pwdata = 32'hF; pstrb = 4'hF;
        #1;
        chk(pslverr === 1'b0, "R12", "no response without setup", 32'(pslverr), 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(irq === {|m1, |m0}, "R12", "irq unchanged without setup", 32'(irq), 32'({|m1, |m0}));
        check_state("R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_same_bit();
        t_upper_bits();
        t_id();
        t_illegal();
        t_protocol();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule